// File: doc/BRIEF.md
# Byte-Masked Partitioned ALU

This block performs arithmetic and logic on a word made of five equal bytes, each `N+1` bits wide. A five-bit byte mask picks the bytes an operation acts on. Each selected byte is computed on its own: no carry or borrow passes between bytes, and the carry out of a byte's top bit is dropped. Bytes that the mask leaves out keep the value they had in the accumulator word.

The block does add and subtract (with a reverse-operand option), load, AND, OR, XOR and complement. Every byte is treated as an unsigned number. A subtraction that would go negative leaves the ones' complement of the magnitude in that byte. The caller presents the accumulator word, the second operand, an opcode and the mask together with a valid pulse. One clock later the new accumulator word appears on a registered output with a one-cycle valid strobe. A mask of all zeros selects full-word mode. Full-word arithmetic is outside this block, so in that case the accumulator word passes through unchanged.

Top module: `byte_alu`

## Requirements
- R1: Byte i occupies word bits [i*(N+1) +: N+1] for i = 0..4, and mask bit i enables byte i. A mask of 11111 applies the operation to all five bytes.
- R2: A byte whose mask bit is 0 keeps its acc_in value in acc_out, whatever the opcode and operand are.
- R3: A mask of 00000 returns acc_in unchanged. Opcode low bits 111 (no-op) also return acc_in unchanged.
- R4: Opcode low bits 000 (add) give (a+b) mod 2^(N+1) in each selected byte. No carry enters the next byte.
- R5: Opcode low bits 001 (subtract) give a-b when opcode bit 3 is 0 and b-a when it is 1. When the result would be negative, the byte holds the bitwise inverse of the magnitude. Equal operands give 0.
- R6: Opcode low bits 010 (load) copy the operand byte into each selected byte.
- R7: Opcode low bits 011, 100 and 101 give the bitwise AND, OR and XOR of the accumulator and operand bytes.
- R8: Opcode low bits 110 (complement) invert the selected accumulator bytes. The operand has no effect.
- R9: The result appears on acc_out one clock after in_valid is sampled high, and out_valid is high for exactly that one cycle. While in_valid is low, acc_out holds its value.
- R10: A synchronous active-high reset clears acc_out and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are presented this cycle |
| op_code | input | 4 | Bits [2:0] select the operation; bit 3 reverses the operands of subtract |
| byte_mask | input | 5 | Byte enables; bit i enables byte i |
| acc_in | input | 5*(N+1) | Accumulator word (first operand) |
| opnd_in | input | 5*(N+1) | Second operand word |
| acc_out | output | 5*(N+1) | Registered new accumulator word |
| out_valid | output | 1 | One-cycle strobe marking a new acc_out |

## Verification
Two functions often fall in the same cycle: a selected byte whose top carry or borrow is being discarded, and the unselected or selected neighbour that must not receive that carry. The bench provokes this with an all-ones byte plus one next to a zero byte, and with a subtraction that goes negative in one byte and stays positive in the byte beside it. It judges the whole word against its own byte-by-byte model and against values worked out by hand. An isolation leak or a mask decode fault shows up as a changed neighbour byte.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int NBYTES = 5;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_LD  = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_CPL = 3'd6,
    OP_NOP = 3'd7
  } alu_op_e;
endpackage

// File: rtl/byte_lane.sv
module byte_lane
  import byte_alu_pkg::*;
#(
  parameter int BW = 11
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  input  alu_op_e       op,
  input  logic          rev,
  input  logic          sel,
  output logic [BW-1:0] y
);
  logic [BW-1:0] res;
  logic [BW-1:0] minu;
  logic [BW-1:0] subt;

  always_comb begin
    minu = rev ? b : a;
    subt = rev ? a : b;
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = (minu >= subt) ? (minu - subt) : ~(subt - minu);
      OP_LD:   res = b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CPL:  res = ~a;
      default: res = a;
    endcase
    y = sel ? res : a;
  end
endmodule

// File: rtl/result_reg.sv
module result_reg #(
  parameter int W = 55
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int N = 10,
  localparam int BW = N + 1,
  localparam int W = NBYTES * BW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [3:0]          op_code,
  input  logic [NBYTES-1:0]   byte_mask,
  input  logic [W-1:0]        acc_in,
  input  logic [W-1:0]        opnd_in,
  output logic [W-1:0]        acc_out,
  output logic                out_valid
);
  alu_op_e     op;
  logic [W-1:0] next_word;

  assign op = alu_op_e'(op_code[2:0]);

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    byte_lane #(.BW(BW)) u_lane (
      .a  (acc_in[i*BW +: BW]),
      .b  (opnd_in[i*BW +: BW]),
      .op (op),
      .rev(op_code[3]),
      .sel(byte_mask[i]),
      .y  (next_word[i*BW +: BW])
    );
  end

  result_reg #(.W(W)) u_reg (
    .clk (clk),
    .rst (rst),
    .load(in_valid),
    .d   (next_word),
    .q   (acc_out),
    .vld (out_valid)
  );
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int BW = 11,
  localparam int W = 5 * BW
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   op_code,
  input logic [4:0]   byte_mask,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] opnd_in,
  input logic [W-1:0] acc_out,
  input logic         out_valid
);
  assert_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(acc_out));

  assert_pass_zero_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(byte_mask) == 5'b0)) |-> (acc_out == $past(acc_in)));

  assert_load_full_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(byte_mask) == 5'b11111) && ($past(op_code[2:0]) == 3'd2))
      |-> (acc_out == $past(opnd_in)));

  for (genvar i = 0; i < 5; i++) begin : g_keep
    assert_keep_unselected_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && !$past(byte_mask[i]))
        |-> (acc_out[i*BW +: BW] == $past(acc_in[i*BW +: BW])));
  end
endmodule

bind byte_alu byte_alu_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
  .byte_mask(byte_mask), .acc_in(acc_in), .opnd_in(opnd_in),
  .acc_out(acc_out), .out_valid(out_valid)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;
  localparam int N  = 10;
  localparam int BW = N + 1;
  localparam int W  = 5 * BW;
  localparam logic [BW-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op_code = '0;
  logic [4:0]   byte_mask = '0;
  logic [W-1:0] acc_in = '0;
  logic [W-1:0] opnd_in = '0;
  logic [W-1:0] acc_out;
  logic         out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byte_alu #(.N(N)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .byte_mask(byte_mask), .acc_in(acc_in), .opnd_in(opnd_in),
    .acc_out(acc_out), .out_valid(out_valid)
  );

  function automatic logic [W-1:0] pack(input int b4, input int b3, input int b2, input int b1, input int b0);
    logic [BW-1:0] v4, v3, v2, v1, v0;
    v4 = BW'(b4); v3 = BW'(b3); v2 = BW'(b2); v1 = BW'(b1); v0 = BW'(b0);
    return {v4, v3, v2, v1, v0};
  endfunction

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic [4:0] m,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    r = a;
    for (int i = 0; i < 5; i++) begin
      int unsigned x, y, t;
      x = a[i*BW +: BW];
      y = b[i*BW +: BW];
      if (m[i]) begin
        case (op[2:0])
          3'd0: t = (x + y) % (1 << BW);
          3'd1: begin
            int unsigned p, q;
            p = op[3] ? y : x;
            q = op[3] ? x : y;
            t = (p >= q) ? (p - q) : (((1 << BW) - 1) - (q - p));
          end
          3'd2: t = y;
          3'd3: t = x & y;
          3'd4: t = x | y;
          3'd5: t = x ^ y;
          3'd6: t = ((1 << BW) - 1) - x;
          default: t = x;
        endcase
        r[i*BW +: BW] = BW'(t);
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [4:0] m,
                        input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_code = op; byte_mask = m; acc_in = a; opnd_in = b;
    @(negedge clk);
    in_valid = 1'b0;
    acc_in = ~a; opnd_in = ~b;
  endtask

  task automatic op_and_check(input string tag, input logic [3:0] op, input logic [4:0] m,
                              input logic [W-1:0] a, input logic [W-1:0] b);
    run_op(op, m, a, b);
    check(tag, acc_out, model(op, m, a, b));
    check({tag, " strobe"}, W'(out_valid), W'(1));
  endtask

  task automatic test_reset();
    check("R10 acc_out reset", acc_out, '0);
    check("R10 out_valid reset", W'(out_valid), '0);
  endtask

  task automatic test_add();
    logic [W-1:0] a, b;
    a = pack(5, 3, ONES, 0, ONES);
    b = pack(7, 4, 1, 0, 1);
    run_op(4'h0, 5'b11111, a, b);
    check("R4 add carry cut", acc_out, pack(12, 7, 0, 0, 0));
    op_and_check("R4 add model", 4'h0, 5'b10101, pack(100, 200, 300, 400, 500), pack(ONES, 2, 3, 4, 5));
  endtask

  task automatic test_sub();
    run_op(4'h1, 5'b11111, pack(9, 3, 5, 0, 1), pack(4, 8, 5, 1, 0));
    check("R5 sub a-b ones complement", acc_out, pack(5, ONES - 5, 0, ONES - 1, 1));
    run_op(4'h9, 5'b11111, pack(9, 3, 5, 0, 1), pack(4, 8, 5, 1, 0));
    check("R5 sub reversed b-a", acc_out, pack(ONES - 5, 5, 0, 1, ONES - 1));
    op_and_check("R5 sub partial", 4'h9, 5'b01011, pack(17, 2000, 3, 1000, 7), pack(18, 1, 30, 999, 7));
  endtask

  task automatic test_load_logic();
    logic [W-1:0] a, b;
    a = pack(12'h5A5, 12'h0F0, 12'h7FF, 12'h123, 12'h001);
    b = pack(12'h3C3, 12'h0FF, 12'h400, 12'h321, 12'h6AA);
    run_op(4'h2, 5'b11111, a, b);
    check("R6 load full", acc_out, b);
    op_and_check("R6 load partial", 4'h2, 5'b10010, a, b);
    op_and_check("R7 and", 4'h3, 5'b11111, a, b);
    op_and_check("R7 or", 4'h4, 5'b01110, a, b);
    op_and_check("R7 xor", 4'h5, 5'b11011, a, b);
  endtask

  task automatic test_cpl();
    logic [W-1:0] a;
    a = pack(1, 2, 3, 4, 5);
    run_op(4'h6, 5'b00101, a, pack(9, 9, 9, 9, 9));
    check("R8 complement operand A", acc_out, pack(1, 2, ONES - 3, 4, ONES - 5));
    run_op(4'h6, 5'b00101, a, '1);
    check("R8 complement operand B", acc_out, pack(1, 2, ONES - 3, 4, ONES - 5));
  endtask

  task automatic test_mask();
    logic [W-1:0] a, b;
    a = pack(11, 22, 33, 44, 55);
    b = pack(66, 77, 88, 99, 111);
    run_op(4'h0, 5'b00000, a, b);
    check("R3 zero mask pass", acc_out, a);
    run_op(4'h7, 5'b11111, a, b);
    check("R3 nop pass", acc_out, a);
    for (int i = 0; i < 5; i++) begin
      logic [W-1:0] e;
      e = a;
      e[i*BW +: BW] = b[i*BW +: BW];
      run_op(4'h2, 5'(1 << i), a, b);
      check($sformatf("R1 byte %0d position", i), acc_out, e);
    end
    run_op(4'h5, 5'b01010, a, b);
    check("R2 unselected kept", acc_out, pack(11, 22 ^ 77, 33, 44 ^ 99, 55));
  endtask

  task automatic test_hold();
    logic [W-1:0] a;
    a = pack(1, 1, 1, 1, 1);
    run_op(4'h0, 5'b11111, a, a);
    @(negedge clk);
    acc_in = '1; opnd_in = '1; op_code = 4'h2; byte_mask = 5'b11111;
    @(negedge clk);
    check("R9 hold value", acc_out, pack(2, 2, 2, 2, 2));
    check("R9 strobe low", W'(out_valid), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    test_add();
    test_sub();
    test_load_logic();
    test_cpl();
    test_mask();
    test_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule